// File: doc/BRIEF.md
# Virtual Interrupt End-of-Interrupt Handler

This block serves the end-of-interrupt register of a virtualized interrupt controller CPU interface. A guest writes the identifier of a finished interrupt to a write-only 32-bit register. The block then lowers the running priority by clearing the most urgent set bit in its active-priorities register. Unless the end-of-interrupt mode bit splits the two effects, it also clears the active state of the matching entry in its bank of list entries.

When the deactivated entry stands for a hardware interrupt, the block raises a deactivate request toward the physical distributor. The request carries the physical identifier stored in that entry and uses a valid/ready handshake. Requests aimed at a Group 0 physical interrupt are discarded while security is enabled. The hypervisor side loads the list entries and the active-priorities register through dedicated load ports, and it observes their state on the outputs.

Top module: `veoi_handler`

## Requirements
- R1: After synchronous reset, `apr_q` is 0, `lr_active` is 0, `pdeact_valid` is 0, `rd_valid` is 0 and `wr_ready` is 1.
- R2: An accepted write has an effect only when `wr_addr` equals offset 0x010. Writes to other offsets are accepted and change nothing.
- R3: A write whose identifier `wr_data[9:0]` is 1020, 1021, 1022 or 1023 changes neither `apr_q` nor `lr_active`, and it raises no request.
- R4: Every other write to 0x010 clears the lowest-numbered set bit of `apr_q` (bit 0 is the most urgent), in either mode. If `apr_q` is 0, it stays 0.
- R5: With `eoi_mode`=0, the write clears the active flag of the lowest-index active entry whose virtual ID equals `wr_data[9:0]`. With `eoi_mode`=1, no entry changes and no request is raised.
- R6: For identifiers 0–15, `wr_data[12:10]` must equal the entry's source CPU for a match. For other identifiers those bits are ignored. Bits [31:13] never affect the result.
- R7: If no active entry matches, only the priority drop occurs. No entry changes and no request is raised.
- R8: A deactivated entry with its hardware flag set raises `pdeact_valid` with `pdeact_id` set to the entry's physical ID, provided that the entry's group-1 flag is 1 or `sec_disable` is 1. Both signals hold steady until `pdeact_ready` is high at a clock edge.
- R9: A deactivated hardware entry with group-1 flag 0 while `sec_disable` is 0 still loses its active flag, but no request is raised.
- R10: `wr_ready` is low while a request is pending and while either load enable is high. A write that is offered during those cycles has no effect.
- R11: A read strobe `rd_en` gives `rd_valid` high one cycle later with `rd_data` equal to 0, and it changes no state.
- R12: `apr_load_en` writes `apr_load_data` into `apr_q`. `lr_load_en` writes `lr_load_data` into entry `lr_load_idx`, with the encoding {phys ID[25:16], virtual ID[15:6], source CPU[5:3], group-1[2], hardware[1], active[0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eoi_mode | input | 1 | 1: priority drop only; 0: drop and deactivate |
| sec_disable | input | 1 | Security-disable setting of the physical distributor |
| wr_valid | input | 1 | Register write offered |
| wr_ready | output | 1 | Register write can be accepted |
| wr_addr | input | ADDR_W | Register write offset |
| wr_data | input | 32 | Register write value |
| rd_en | input | 1 | Register read strobe |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read data, always zero |
| apr_load_en | input | 1 | Load the active-priorities register |
| apr_load_data | input | APR_W | Value to load |
| lr_load_en | input | 1 | Load one list entry |
| lr_load_idx | input | IDX_W | Entry to load |
| lr_load_data | input | 26 | Encoded entry |
| apr_q | output | APR_W | Active-priorities register |
| lr_active | output | NUM_LR | Active flag of each entry |
| pdeact_valid | output | 1 | Physical deactivate request pending |
| pdeact_ready | input | 1 | Distributor accepts the request |
| pdeact_id | output | 10 | Physical ID of the request |

## Verification
The assertions take for granted that the load ports and the write port never compete, because `wr_ready` falls whenever a load enable is high. They also assume that `pdeact_ready` is an ordinary input sampled only while a request is pending. The stimulus never raises a load enable in a cycle that is meant to carry a write. It loads the bank and the active-priorities register in separate cycles before each write, and it drives `pdeact_ready` only after checking the pending request. The only deliberate overlap is a write offered during a pending request, which exercises the back-pressure.

// File: rtl/veoi_pkg.sv
package veoi_pkg;
  localparam int ID_W   = 10;
  localparam int SRC_W  = 3;
  localparam int LR_W   = 2 * ID_W + SRC_W + 3;
  localparam int SPUR_LO = 1020;
  localparam int SGI_LIM = 16;

  // Field order matches the flat load encoding, MSB first.
  typedef struct packed {
    logic [ID_W-1:0]  pid;
    logic [ID_W-1:0]  vid;
    logic [SRC_W-1:0] src;
    logic             grp1;
    logic             hw;
    logic             act;
  } lr_ent_t;
endpackage

// File: rtl/veoi_prio_drop.sv
module veoi_prio_drop #(
  parameter int W = 32
) (
  input  logic [W-1:0] apr_i,
  output logic [W-1:0] apr_o
);
  // Lowest-numbered set bit is the most urgent; x & (x-1) removes it.
  assign apr_o = apr_i & (apr_i - W'(1));
endmodule

// File: rtl/veoi_lr_match.sv
module veoi_lr_match
  import veoi_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  lr_ent_t [N-1:0]  ents,
  input  logic [ID_W-1:0]  id,
  input  logic [SRC_W-1:0] src,
  input  logic             is_sgi,
  output logic             hit,
  output logic [IW-1:0]    idx
);
  logic [N-1:0] m;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign m[g] = ents[g].act && (ents[g].vid == id) &&
                  (!is_sgi || (ents[g].src == src));
  end

  // Lowest index wins when several entries match.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/veoi_handler.sv
module veoi_handler
  import veoi_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] EOI_OFS = 12'h010,
  parameter int APR_W   = 32,
  parameter int NUM_LR  = 4,
  localparam int IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eoi_mode,
  input  logic              sec_disable,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              apr_load_en,
  input  logic [APR_W-1:0]  apr_load_data,
  input  logic              lr_load_en,
  input  logic [IDX_W-1:0]  lr_load_idx,
  input  logic [LR_W-1:0]   lr_load_data,
  output logic [APR_W-1:0]  apr_q,
  output logic [NUM_LR-1:0] lr_active,
  output logic              pdeact_valid,
  input  logic              pdeact_ready,
  output logic [ID_W-1:0]   pdeact_id
);
  lr_ent_t [NUM_LR-1:0] lr_q;
  logic [APR_W-1:0]     apr_drop;
  logic [ID_W-1:0]      eid;
  logic [SRC_W-1:0]     esrc;
  logic                 wr_fire, hit_reg, spurious, is_sgi, do_eoi;
  logic                 m_hit, deact, fwd;
  logic [IDX_W-1:0]     m_idx;
  logic                 unused_hi;

  assign unused_hi = ^wr_data[31:ID_W+SRC_W];

  assign eid      = wr_data[ID_W-1:0];
  assign esrc     = wr_data[ID_W+SRC_W-1:ID_W];
  assign spurious = (eid >= ID_W'(SPUR_LO));
  assign is_sgi   = (eid < ID_W'(SGI_LIM));

  assign wr_ready = !pdeact_valid && !apr_load_en && !lr_load_en;
  assign wr_fire  = wr_valid && wr_ready;
  assign hit_reg  = wr_fire && (wr_addr == EOI_OFS);
  assign do_eoi   = hit_reg && !spurious;

  veoi_prio_drop #(.W(APR_W)) u_drop (
    .apr_i (apr_q),
    .apr_o (apr_drop)
  );

  veoi_lr_match #(.N(NUM_LR)) u_match (
    .ents   (lr_q),
    .id     (eid),
    .src    (esrc),
    .is_sgi (is_sgi),
    .hit    (m_hit),
    .idx    (m_idx)
  );

  assign deact = do_eoi && !eoi_mode && m_hit;
  assign fwd   = deact && lr_q[m_idx].hw && (lr_q[m_idx].grp1 || sec_disable);

  always_ff @(posedge clk) begin
    if (rst) begin
      apr_q        <= '0;
      lr_q         <= '0;
      pdeact_valid <= 1'b0;
      pdeact_id    <= '0;
      rd_valid     <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (apr_load_en)
        apr_q <= apr_load_data;
      else if (do_eoi)
        apr_q <= apr_drop;
      if (lr_load_en)
        lr_q[lr_load_idx] <= lr_ent_t'(lr_load_data);
      else if (deact)
        lr_q[m_idx].act <= 1'b0;
      if (pdeact_valid && pdeact_ready)
        pdeact_valid <= 1'b0;
      if (fwd) begin
        pdeact_valid <= 1'b1;
        pdeact_id    <= lr_q[m_idx].pid;
      end
    end
  end

  assign rd_data = '0;

  for (genvar g = 0; g < NUM_LR; g++) begin : g_act
    assign lr_active[g] = lr_q[g].act;
  end

  // Reserved identifiers leave every piece of state alone.
  p_spurious_noop_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && wr_addr == EOI_OFS && wr_data[ID_W-1:0] >= ID_W'(SPUR_LO))
    |=> ($stable(apr_q) && $stable(lr_active) && !$rose(pdeact_valid)));

  // A drop removes exactly one bit and never sets one.
  p_drop_one_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (do_eoi && apr_q != '0)
    |=> ($countones(apr_q) == $countones($past(apr_q)) - 1) &&
        ((apr_q & ~$past(apr_q)) == '0));

  // Drop-only mode leaves the bank untouched.
  p_mode1_keeps_bank_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && eoi_mode) |=> $stable(lr_active));

  // Pending request is held steady until taken.
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (pdeact_valid && !pdeact_ready) |=> (pdeact_valid && $stable(pdeact_id)));

  // No write is taken while a request is outstanding.
  p_backpressure_r10: assert property (@(posedge clk) disable iff (rst)
    pdeact_valid |-> !wr_ready);

  // At most one entry loses its active flag per write.
  p_single_deact_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> $countones($past(lr_active) & ~lr_active) <= 1);
endmodule

// File: tb/test_veoi_handler.sv
module test_veoi_handler;
  localparam int NL = 4;
  localparam logic [11:0] OFS = 12'h010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eoi_mode = 1'b0, sec_disable = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic rd_en = 1'b0, rd_valid;
  logic [31:0] rd_data;
  logic apr_load_en = 1'b0;
  logic [31:0] apr_load_data = '0;
  logic lr_load_en = 1'b0;
  logic [1:0] lr_load_idx = '0;
  logic [25:0] lr_load_data = '0;
  logic [31:0] apr_q;
  logic [NL-1:0] lr_active;
  logic pdeact_valid, pdeact_ready = 1'b0;
  logic [9:0] pdeact_id;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  veoi_handler i_veoi_handler (
    .clk, .rst, .eoi_mode, .sec_disable, .wr_valid, .wr_ready, .wr_addr,
    .wr_data, .rd_en, .rd_valid, .rd_data, .apr_load_en, .apr_load_data,
    .lr_load_en, .lr_load_idx, .lr_load_data, .apr_q, .lr_active,
    .pdeact_valid, .pdeact_ready, .pdeact_id
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic [31:0] apr;
    logic        mode;
    logic        sd;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] eapr;
    logic [3:0]  eact;
    logic        ereq;
    logic [9:0]  epid;
  } vec_t;

  // Bank: e0 vid 40; e1 vid 5 src 3 (SGI); e2 vid 77 hw grp1 pid 300; e3 vid 90 hw grp0 pid 411
  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{4'd5, 32'h0000_00F0, 1'b0, 1'b0, 12'h010, 32'h0000_0028, 32'h0000_00E0, 4'b1110, 1'b0, 10'd0},   // R5 R4
    '{4'd5, 32'h8000_0001, 1'b1, 1'b0, 12'h010, 32'h0000_0028, 32'h8000_0000, 4'b1111, 1'b0, 10'd0},   // R5 mode 1
    '{4'd3, 32'h0000_000C, 1'b0, 1'b0, 12'h010, 32'h0000_03FE, 32'h0000_000C, 4'b1111, 1'b0, 10'd0},   // R3
    '{4'd2, 32'h0000_000C, 1'b0, 1'b0, 12'h014, 32'h0000_0028, 32'h0000_000C, 4'b1111, 1'b0, 10'd0},   // R2
    '{4'd6, 32'h0000_0003, 1'b0, 1'b0, 12'h010, 32'h0000_0C05, 32'h0000_0002, 4'b1101, 1'b0, 10'd0},   // R6 SGI src ok
    '{4'd6, 32'h0000_0003, 1'b0, 1'b0, 12'h010, 32'h0000_0805, 32'h0000_0002, 4'b1111, 1'b0, 10'd0},   // R6 SGI src bad
    '{4'd6, 32'h0000_0010, 1'b0, 1'b0, 12'h010, 32'hFEFF_FC28, 32'h0000_0000, 4'b1110, 1'b0, 10'd0},   // R6 upper bits
    '{4'd8, 32'h0000_0000, 1'b0, 1'b0, 12'h010, 32'h0000_004D, 32'h0000_0000, 4'b1011, 1'b1, 10'd300}, // R8 R4 empty apr
    '{4'd9, 32'h0000_0100, 1'b0, 1'b0, 12'h010, 32'h0000_005A, 32'h0000_0000, 4'b0111, 1'b0, 10'd0},   // R9
    '{4'd9, 32'h0000_0100, 1'b0, 1'b1, 12'h010, 32'h0000_005A, 32'h0000_0000, 4'b0111, 1'b1, 10'd411}, // R9 sd=1
    '{4'd7, 32'h0000_0006, 1'b0, 1'b0, 12'h010, 32'h0000_007B, 32'h0000_0004, 4'b1111, 1'b0, 10'd0},   // R7
    '{4'd5, 32'h0000_0006, 1'b1, 1'b0, 12'h010, 32'h0000_004D, 32'h0000_0004, 4'b1111, 1'b0, 10'd0},   // R5 mode 1 hw
    '{4'd3, 32'h0000_0001, 1'b0, 1'b0, 12'h010, 32'h0000_03FC, 32'h0000_0001, 4'b1111, 1'b0, 10'd0},   // R3 1020
    '{4'd3, 32'h0000_0001, 1'b0, 1'b0, 12'h010, 32'h0000_03FF, 32'h0000_0001, 4'b1111, 1'b0, 10'd0},   // R3 1023
    '{4'd4, 32'h8000_0000, 1'b1, 1'b0, 12'h010, 32'h0000_0028, 32'h0000_0000, 4'b1111, 1'b0, 10'd0}    // R4 bit 31
  };

  function automatic logic [25:0] enc(input logic [9:0] pid, input logic [9:0] vid,
                                      input logic [2:0] src, input logic g1,
                                      input logic hw, input logic act);
    return {pid, vid, src, g1, hw, act};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic load_lr(input int idx, input logic [25:0] d);
    lr_load_en = 1'b1; lr_load_idx = 2'(idx); lr_load_data = d;
    @(negedge clk);
    lr_load_en = 1'b0;
  endtask

  task automatic load_apr(input logic [31:0] d);
    apr_load_en = 1'b1; apr_load_data = d;
    @(negedge clk);
    apr_load_en = 1'b0;
  endtask

  task automatic load_bank();
    load_lr(0, enc(10'd0,   10'd40, 3'd0, 1'b0, 1'b0, 1'b1));
    load_lr(1, enc(10'd0,   10'd5,  3'd3, 1'b0, 1'b0, 1'b1));
    load_lr(2, enc(10'd300, 10'd77, 3'd0, 1'b1, 1'b1, 1'b1));
    load_lr(3, enc(10'd411, 10'd90, 3'd0, 1'b0, 1'b1, 1'b1));
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic ack();
    pdeact_ready = 1'b1;
    @(negedge clk);
    pdeact_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(apr_q == 0, "R1", "apr_q", apr_q, 0);
    chk(lr_active == 0, "R1", "lr_active", 32'(lr_active), 0);
    chk(!pdeact_valid, "R1", "pdeact_valid", 32'(pdeact_valid), 0);
    chk(wr_ready, "R1", "wr_ready", 32'(wr_ready), 1);
    chk(!rd_valid, "R1", "rd_valid", 32'(rd_valid), 0);

    for (int v = 0; v < NV; v++) begin
      string t;
      t = $sformatf("R%0d vec%0d", TBL[v].tag, v);
      load_bank();
      load_apr(TBL[v].apr);
      eoi_mode = TBL[v].mode; sec_disable = TBL[v].sd;
      wr(TBL[v].addr, TBL[v].wd);
      chk(apr_q == TBL[v].eapr, t, "apr_q", apr_q, TBL[v].eapr);
      chk(lr_active == TBL[v].eact, t, "lr_active", 32'(lr_active), 32'(TBL[v].eact));
      chk(pdeact_valid == TBL[v].ereq, t, "pdeact_valid", 32'(pdeact_valid), 32'(TBL[v].ereq));
      if (TBL[v].ereq) begin
        chk(pdeact_id == TBL[v].epid, t, "pdeact_id", 32'(pdeact_id), 32'(TBL[v].epid));
        ack();
        chk(!pdeact_valid && wr_ready, t, "request cleared", 32'(pdeact_valid), 0);
      end
    end
    eoi_mode = 1'b0; sec_disable = 1'b0;

    // R12 load ports
    load_apr(32'hA5A5_0F0F);
    chk(apr_q == 32'hA5A5_0F0F, "R12", "apr load", apr_q, 32'hA5A5_0F0F);
    load_lr(2, enc(10'd300, 10'd77, 3'd0, 1'b1, 1'b1, 1'b0));
    chk(lr_active == 4'b1011, "R12", "entry load", 32'(lr_active), 32'hB);

    // R11 read returns zero, no state change
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid && rd_data == 0, "R11", "read data", rd_data, 0);
    chk(apr_q == 32'hA5A5_0F0F && lr_active == 4'b1011, "R11", "state after read", apr_q, 32'hA5A5_0F0F);

    // R10 wr_ready low during a load
    apr_load_en = 1'b1; apr_load_data = 32'h3;
    #1;
    chk(!wr_ready, "R10", "wr_ready during load", 32'(wr_ready), 0);
    @(negedge clk);
    apr_load_en = 1'b0;

    // R8 hold and R10 back-pressure
    load_bank();
    wr(OFS, 32'h4D);
    repeat (3) @(negedge clk);
    chk(pdeact_valid && pdeact_id == 10'd300, "R8", "held request", 32'(pdeact_id), 300);
    chk(!wr_ready, "R10", "wr_ready while pending", 32'(wr_ready), 0);
    wr_valid = 1'b1; wr_addr = OFS; wr_data = 32'h28;
    repeat (2) @(negedge clk);
    wr_valid = 1'b0;
    chk(lr_active[0] && apr_q == 32'h2, "R10", "blocked write effect", apr_q, 32'h2);
    ack();
    chk(!pdeact_valid && wr_ready, "R8", "release after ready", 32'(pdeact_valid), 0);

    // R1 reset again clears state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(apr_q == 0 && lr_active == 0, "R1", "re-reset", apr_q, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule